// File: doc/BRIEF.md
# I2C Byte Shifter with Acknowledge Slot

This block sits between a byte-level I2C controller and the bus timing logic. It serializes one byte onto SDA when transmitting, or collects SDA bits into a byte when receiving. After the data bits it always runs a single acknowledge slot.

When transmitting, the block releases SDA in the acknowledge slot and captures the other side's answer. When receiving, it drives its own configured answer in that slot: low means ACK (continue) and high means NACK (stop). Bit order is chosen separately for each direction, LSB-first or MSB-first.

The controller hands over a byte, direction and options with a one-cycle load pulse. The timing logic then gives one shift strobe per slot, while SCL is low, to update SDA. It gives one sample strobe per slot, while SCL is high, to read SDA. A load that arrives while a byte is in flight is dropped and reported.

Top module: `i2c_byte_shifter`

## Requirements
- R1: Synchronous reset leaves the block idle: `busy` low, `sdaOut` high (released), and `byteValid`, `ackValid` and `loadErr` low.
- R2: A `loadValid` pulse while idle is accepted. `busy` is high from the next cycle. The direction (`loadTx`: 1 transmit, 0 receive), both bit-order inputs and `ackLevel` are captured at that moment.
- R3: When transmitting, the shift strobe of data slot k (k = 0 first) sets `sdaOut` on the following cycle. It takes bit k of the byte when `txLsbFirst` was 1, and bit DATA_W-1-k when it was 0. `sdaOut` changes only on a shift strobe.
- R4: When transmitting, `sdaOut` is 1 during the acknowledge slot (slot DATA_W). The sample strobe of that slot stores `sdaIn` in `ackBit` (0 = ACK, 1 = NACK), and `ackValid` pulses for one cycle on the following cycle.
- R5: When receiving, the bit sampled in data slot 0 lands in bit 0 of `rxByte` when `rxLsbFirst` was 1, and in bit DATA_W-1 when it was 0. Later slots fill the following positions in the same direction.
- R6: When receiving, `sdaOut` is 1 in every data slot. In the acknowledge slot it takes the captured `ackLevel` (0 = ACK, 1 = NACK).
- R7: When receiving, `byteValid` pulses for one cycle on the cycle after the acknowledge-slot sample strobe, with the complete byte on `rxByte`. `byteValid` and `ackValid` are never high together.
- R8: A `loadValid` pulse while `busy` is high is ignored: the byte in flight completes unchanged, and `loadErr` pulses for one cycle on the next cycle.
- R9: `busy` falls on the cycle after the acknowledge-slot sample strobe, and a new load is then accepted. While idle, sample strobes have no effect and a shift strobe releases SDA (`sdaOut` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loadValid | input | 1 | One-cycle request to start a byte |
| loadData | input | DATA_W | Byte to transmit (unused when receiving) |
| loadTx | input | 1 | 1 transmit, 0 receive |
| txLsbFirst | input | 1 | Transmit order: 1 LSB first, 0 MSB first |
| rxLsbFirst | input | 1 | Receive order: 1 first bit is LSB, 0 first bit is MSB |
| ackLevel | input | 1 | Level driven in the acknowledge slot when receiving |
| loadErr | output | 1 | Pulse: load arrived while busy and was dropped |
| busy | output | 1 | A byte is in flight |
| shiftStrobe | input | 1 | Update SDA for the current slot |
| sampleStrobe | input | 1 | Read SDA for the current slot |
| sdaIn | input | 1 | SDA line level |
| sdaOut | output | 1 | SDA drive, 0 pulls low, 1 releases |
| byteValid | output | 1 | Pulse: received byte ready |
| rxByte | output | DATA_W | Last received byte |
| ackValid | output | 1 | Pulse: acknowledge of a transmitted byte captured |
| ackBit | output | 1 | Captured acknowledge, 0 ACK, 1 NACK |

## Verification
The bench builds the block with DATA_W = 8, which keeps the full byte space small enough to sweep completely. Every one of the 256 byte values is sent in both transmit orders and received in both receive orders. The answer on the line and the block's own acknowledge level alternate across the sweep, so both ACK and NACK are seen in each direction. A load dropped mid-transfer and strobes arriving while idle are exercised on top of the sweep.

// File: rtl/i2c_shift_pkg.sv
package i2c_shift_pkg;

  typedef struct packed {
    logic load;        // accept a new byte this cycle
    logic shiftData;   // drive next transmit data bit
    logic driveAck;    // drive own acknowledge level (receive)
    logic relSda;      // release SDA on this shift strobe
    logic sampleData;  // shift a received bit in
    logic sampleAck;   // acknowledge slot sampled
    logic txMode;      // latched direction
    logic txLsb;       // latched transmit order
    logic rxLsb;       // latched receive order
    logic ackLvl;      // latched acknowledge level
  } shCtl_t;

endpackage

// File: rtl/i2c_shift_ctrl.sv
module i2c_shift_ctrl
  import i2c_shift_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   loadValid,
  input  logic   loadTx,
  input  logic   txLsbFirst,
  input  logic   rxLsbFirst,
  input  logic   ackLevel,
  input  logic   shiftStrobe,
  input  logic   sampleStrobe,
  output shCtl_t ctl,
  output logic   busy,
  output logic   loadErr,
  output logic   byteValid,
  output logic   ackValid
);

  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);

  logic [CNT_W-1:0] slotCnt;
  logic             txModeQ, txLsbQ, rxLsbQ, ackLvlQ;
  logic             acceptLoad, inData, inAck;

  assign acceptLoad = loadValid && !busy;
  assign inData     = busy && (slotCnt < ACK_SLOT);
  assign inAck      = busy && (slotCnt == ACK_SLOT);

  always_comb begin
    ctl            = '0;
    ctl.load       = acceptLoad;
    ctl.shiftData  = shiftStrobe && inData && txModeQ;
    ctl.driveAck   = shiftStrobe && inAck && !txModeQ;
    ctl.relSda     = shiftStrobe && !(ctl.shiftData || ctl.driveAck);
    ctl.sampleData = sampleStrobe && inData && !txModeQ;
    ctl.sampleAck  = sampleStrobe && inAck;
    ctl.txMode     = txModeQ;
    ctl.txLsb      = txLsbQ;
    ctl.rxLsb      = rxLsbQ;
    ctl.ackLvl     = ackLvlQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      slotCnt   <= '0;
      txModeQ   <= 1'b0;
      txLsbQ    <= 1'b0;
      rxLsbQ    <= 1'b0;
      ackLvlQ   <= 1'b0;
      loadErr   <= 1'b0;
      byteValid <= 1'b0;
      ackValid  <= 1'b0;
    end else begin
      loadErr   <= loadValid && busy;
      byteValid <= 1'b0;
      ackValid  <= 1'b0;
      if (acceptLoad) begin
        busy    <= 1'b1;
        slotCnt <= '0;
        txModeQ <= loadTx;
        txLsbQ  <= txLsbFirst;
        rxLsbQ  <= rxLsbFirst;
        ackLvlQ <= ackLevel;
      end else if (busy && sampleStrobe) begin
        if (slotCnt == ACK_SLOT) begin
          busy    <= 1'b0;
          slotCnt <= '0;
          if (txModeQ) ackValid  <= 1'b1;
          else         byteValid <= 1'b1;
        end else begin
          slotCnt <= slotCnt + 1'b1;
        end
      end
    end
  end

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !busy |-> slotCnt == '0);                                           // R1
  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
    (loadValid && !busy) |=> (busy && slotCnt == '0));                  // R2
  AST_LOAD_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (loadValid && busy && !sampleStrobe) |=> (busy && loadErr));        // R8
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(byteValid && ackValid));                                          // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (byteValid || ackValid) |-> !busy);                                 // R9
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slotCnt <= ACK_SLOT);                                               // R9

endmodule

// File: rtl/i2c_shift_dp.sv
module i2c_shift_dp
  import i2c_shift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  shCtl_t            ctl,
  input  logic [DATA_W-1:0] loadData,
  input  logic              sdaIn,
  output logic              sdaOut,
  output logic [DATA_W-1:0] rxByte,
  output logic              ackBit
);

  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] shNext;
  logic              txBit;

  // transmit bit leaves from the end chosen by the order
  assign txBit = ctl.txLsb ? shReg[0] : shReg[DATA_W-1];

  always_comb begin
    shNext = shReg;
    if (ctl.load) begin
      shNext = loadData;
    end else if (ctl.shiftData) begin
      shNext = ctl.txLsb ? {1'b0, shReg[DATA_W-1:1]}
                         : {shReg[DATA_W-2:0], 1'b0};
    end else if (ctl.sampleData) begin
      // LSB-first enters at the top and walks down; MSB-first enters at the bottom
      shNext = ctl.rxLsb ? {sdaIn, shReg[DATA_W-1:1]}
                         : {shReg[DATA_W-2:0], sdaIn};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg  <= '0;
      sdaOut <= 1'b1;
      rxByte <= '0;
      ackBit <= 1'b0;
    end else begin
      shReg <= shNext;
      if (ctl.shiftData)     sdaOut <= txBit;
      else if (ctl.driveAck) sdaOut <= ctl.ackLvl;
      else if (ctl.relSda)   sdaOut <= 1'b1;
      if (ctl.sampleAck) begin
        if (ctl.txMode) ackBit <= sdaIn;
        else            rxByte <= shReg;
      end
    end
  end

  AST_SDA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(ctl.shiftData || ctl.driveAck || ctl.relSda) |=> $stable(sdaOut)); // R3
  AST_SDA_RELEASED: assert property (@(posedge clk) disable iff (rst)
    ctl.relSda |=> sdaOut);                                             // R6
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.shiftData, ctl.driveAck, ctl.relSda}));              // R3
  AST_RXBYTE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl.sampleAck |=> $stable(rxByte));                                // R7

endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
  import i2c_shift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadValid,
  input  logic [DATA_W-1:0] loadData,
  input  logic              loadTx,
  input  logic              txLsbFirst,
  input  logic              rxLsbFirst,
  input  logic              ackLevel,
  output logic              loadErr,
  output logic              busy,
  input  logic              shiftStrobe,
  input  logic              sampleStrobe,
  input  logic              sdaIn,
  output logic              sdaOut,
  output logic              byteValid,
  output logic [DATA_W-1:0] rxByte,
  output logic              ackValid,
  output logic              ackBit
);

  shCtl_t ctl;

  i2c_shift_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .loadValid(loadValid), .loadTx(loadTx),
    .txLsbFirst(txLsbFirst), .rxLsbFirst(rxLsbFirst), .ackLevel(ackLevel),
    .shiftStrobe(shiftStrobe), .sampleStrobe(sampleStrobe),
    .ctl(ctl), .busy(busy), .loadErr(loadErr),
    .byteValid(byteValid), .ackValid(ackValid)
  );

  i2c_shift_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .loadData(loadData), .sdaIn(sdaIn),
    .sdaOut(sdaOut), .rxByte(rxByte), .ackBit(ackBit)
  );

endmodule

// File: tb/i2c_byte_shifter_bench.sv
module i2c_byte_shifter_bench;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadValid = 1'b0, loadTx = 1'b0, txLsbFirst = 1'b0, rxLsbFirst = 1'b0;
  logic ackLevel = 1'b0, shiftStrobe = 1'b0, sampleStrobe = 1'b0, sdaIn = 1'b1;
  logic [W-1:0] loadData = '0;
  logic loadErr, busy, sdaOut, byteValid, ackValid, ackBit;
  logic [W-1:0] rxByte;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  i2c_byte_shifter #(.DATA_W(W)) u_i2c_byte_shifter (
    .clk(clk), .rst(rst), .loadValid(loadValid), .loadData(loadData),
    .loadTx(loadTx), .txLsbFirst(txLsbFirst), .rxLsbFirst(rxLsbFirst),
    .ackLevel(ackLevel), .loadErr(loadErr), .busy(busy),
    .shiftStrobe(shiftStrobe), .sampleStrobe(sampleStrobe), .sdaIn(sdaIn),
    .sdaOut(sdaOut), .byteValid(byteValid), .rxByte(rxByte),
    .ackValid(ackValid), .ackBit(ackBit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doLoad(input logic [W-1:0] d, input logic tx, input logic tl,
                        input logic rl, input logic al);
    loadValid = 1'b1; loadData = d; loadTx = tx;
    txLsbFirst = tl; rxLsbFirst = rl; ackLevel = al;
    tick();
    loadValid = 1'b0;
    // scramble the live options: they must have been captured at load
    txLsbFirst = ~tl; rxLsbFirst = ~rl; ackLevel = ~al; loadTx = ~tx;
    chk(busy === 1'b1, "R2 busy after load", busy, 1);
  endtask

  task automatic shiftSlot();
    shiftStrobe = 1'b1; tick(); shiftStrobe = 1'b0;
  endtask

  task automatic sampleSlot(input logic b);
    sdaIn = b; sampleStrobe = 1'b1; tick(); sampleStrobe = 1'b0; sdaIn = 1'b1;
  endtask

  task automatic txByte(input logic [W-1:0] d, input logic tl, input logic lineAck,
                        input bit midLoad);
    logic expBit;
    doLoad(d, 1'b1, tl, 1'b0, 1'b0);
    for (int k = 0; k < W; k++) begin
      shiftSlot();
      expBit = tl ? d[k] : d[W-1-k];
      chk(sdaOut === expBit, "R3 tx data bit", sdaOut, expBit);
      if (midLoad && k == 3) begin
        loadValid = 1'b1; loadData = ~d; loadTx = 1'b0; tick(); loadValid = 1'b0;
        chk(loadErr === 1'b1, "R8 loadErr pulse", loadErr, 1);
        tick();
        chk(loadErr === 1'b0, "R8 loadErr one cycle", loadErr, 0);
      end
      sampleSlot(expBit);
    end
    shiftSlot();
    chk(sdaOut === 1'b1, "R4 tx ack slot released", sdaOut, 1);
    sampleSlot(lineAck);
    chk(ackValid === 1'b1 && ackBit === lineAck, "R4 ack captured",
        {ackValid, ackBit}, {1'b1, lineAck});
    chk(busy === 1'b0 && byteValid === 1'b0, "R9 idle after tx",
        {busy, byteValid}, 0);
    tick();
    chk(ackValid === 1'b0, "R4 ackValid one cycle", ackValid, 0);
  endtask

  task automatic rxByteRun(input logic [W-1:0] d, input logic rl, input logic al);
    logic lineBit;
    doLoad(~d, 1'b0, 1'b0, rl, al);
    for (int k = 0; k < W; k++) begin
      shiftSlot();
      chk(sdaOut === 1'b1, "R6 rx data slot released", sdaOut, 1);
      lineBit = rl ? d[k] : d[W-1-k];
      sampleSlot(lineBit);
    end
    shiftSlot();
    chk(sdaOut === al, "R6 rx ack level", sdaOut, al);
    sampleSlot(1'b1);
    chk(byteValid === 1'b1 && ackValid === 1'b0, "R7 byteValid pulse",
        {byteValid, ackValid}, 2'b10);
    chk(rxByte === d, "R5 rx byte order", rxByte, d);
    chk(busy === 1'b0, "R9 idle after rx", busy, 0);
    tick();
    chk(byteValid === 1'b0, "R7 byteValid one cycle", byteValid, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk(busy === 1'b0 && sdaOut === 1'b1, "R1 reset idle/released", {busy, sdaOut}, 2'b01);
    chk({byteValid, ackValid, loadErr} === 3'b000, "R1 reset pulses low",
        {byteValid, ackValid, loadErr}, 0);

    // idle sample strobes do nothing
    sampleSlot(1'b0);
    chk(busy === 1'b0 && byteValid === 1'b0 && ackValid === 1'b0,
        "R9 idle sample ignored", {busy, byteValid, ackValid}, 0);

    for (int tl = 0; tl < 2; tl++)
      for (int d = 0; d < (1 << W); d++)
        txByte(W'(d), tl[0], d[0] ^ tl[0], 1'b0);

    for (int rl = 0; rl < 2; rl++)
      for (int d = 0; d < (1 << W); d++)
        rxByteRun(W'(d), rl[0], d[1] ^ rl[0]);

    // load while busy is dropped, in-flight byte unchanged
    txByte(8'hA5, 1'b0, 1'b0, 1'b1);
    txByte(8'h3C, 1'b1, 1'b1, 1'b1);

    // after rx with ACK low, idle shift strobe releases SDA
    rxByteRun(8'h96, 1'b0, 1'b0);
    chk(sdaOut === 1'b0, "R6 ack held until next shift", sdaOut, 0);
    shiftSlot();
    chk(sdaOut === 1'b1 && busy === 1'b0, "R9 idle shift releases", {sdaOut, busy}, 2'b10);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule